// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small register-file microcontroller core. Each cycle it takes two 8-bit operands and a 5-bit operation code and combinationally produces an 8-bit result. It also raises a result write enable, which tells the register file whether to store that result. A separate equality strobe serves a compare-and-skip operation.

A six-bit status register sits next to the datapath. It is updated on the rising clock edge when `flag_we_i` is high. Each operation has its own mask of the flags it may touch, and the flags outside that mask keep their value. The stored carry is the carry input for the chained forms: add-with-carry, subtract-with-carry, compare-with-carry and the rotates.

An immediate operand arrives on `b_i`, just as a register operand does. Compare-immediate is therefore the compare code used with an immediate value.

Top module: `alu8_flags`

## Requirements
- R1: `flags_o` bit order is [0]=C, [1]=Z, [2]=N, [3]=V, [4]=S, [5]=H. Reset clears all six bits. The flags change only on a rising clock edge with `flag_we_i` high, and only in the bits that the current operation updates.
- R2: Op codes are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, NEG=6, COM=7, INC=8, DEC=9, AND=10, OR=11, LSL=12, LSR=13, ROL=14, ROR=15, SWAP=16, MOV=17, CPSE=18. Any other code writes no result, updates no flag and gives a result equal to `a_i`.
- R3: ADD gives a+b and ADC gives a+b+C. C is the carry out of bit 7 and H is the carry out of bit 3. V is set when both operands have the same sign and the result's sign differs from it.
- R4: SUB gives a-b and SBC gives a-b-C. C is the borrow out of bit 7 and H is the borrow out of bit 3. V is set when the operands differ in sign and the result's sign differs from a. For SBC, Z can only be cleared and is never set: it becomes old Z AND (result==0).
- R5: CP and CPC update all six flags exactly as SUB and SBC do, including the sticky Z of CPC. Both hold `result_we_o` low.
- R6: CPSE holds `result_we_o` low and changes no flag. It drives `equal_o` high exactly when a_i==b_i. `equal_o` is low for every other op.
- R7: NEG gives 0-a, so 0x01→0xFF, 0xFF→0x01, 0x00→0x00 and 0x80→0x80. All flags are updated as for a subtraction from zero.
- R8: COM gives ~a. It sets C to 1 and V to 0, and leaves H unchanged.
- R9: INC gives a+1 and DEC gives a-1. Both update Z, N, V and S, and keep C and H. V is set for INC of 0x7F and for DEC of 0x80.
- R10: AND and OR give the bitwise result and clear V. C and H keep their value.
- R11: Shifts and rotates leave H unchanged and set V = N XOR C. LSL gives {a[6:0],0} and LSR gives {0,a[7:1]}. ROL gives {a[6:0],C}, ROR gives {C,a[7:1]}. The bit shifted out becomes C.
- R12: SWAP gives {a[3:0],a[7:4]} (0xFA→0xAF). MOV gives b. Neither changes any flag.
- R13: For every op that updates flags, N equals result bit 7 and S equals N XOR V. Z is set when the result is zero, except in the sticky case of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code (R2) |
| a_i | input | 8 | First operand (destination register) |
| b_i | input | 8 | Second operand, register or immediate |
| flag_we_i | input | 1 | Allows the status register to update this cycle |
| result_o | output | 8 | Combinational result |
| result_we_o | output | 1 | Result should be written back |
| equal_o | output | 1 | Equality strobe for compare-and-skip |
| flags_o | output | 6 | Stored flags {H,S,V,N,Z,C} |

## Verification
The assertions assume that `op_i`, `a_i`, `b_i` and `flag_we_i` are stable around each rising edge. The stimulus meets this by changing every input only on the falling edge. Under that assumption, the flag properties can tie a sampled op to the flag value one cycle later. Directed sequences chain ADC and SBC/CPC across bytes so that both the stored carry and the sticky Z are exercised, and they also drive the sign-boundary values for NEG, INC and DEC. A stretch of random ops, operands and write enables then covers the rest of the masks. Cycles with `flag_we_i` low are mixed in to show that the flags hold.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned OW = 5;
  localparam int unsigned FW = 6;
  localparam int unsigned F_C = 0;
  localparam int unsigned F_Z = 1;
  localparam int unsigned F_N = 2;
  localparam int unsigned F_V = 3;
  localparam int unsigned F_S = 4;
  localparam int unsigned F_H = 5;

  typedef enum logic [OW-1:0] {
    OP_ADD = 5'd0, OP_ADC = 5'd1, OP_SUB = 5'd2, OP_SBC = 5'd3,
    OP_CP  = 5'd4, OP_CPC = 5'd5, OP_NEG = 5'd6, OP_COM = 5'd7,
    OP_INC = 5'd8, OP_DEC = 5'd9, OP_AND = 5'd10, OP_OR = 5'd11,
    OP_LSL = 5'd12, OP_LSR = 5'd13, OP_ROL = 5'd14, OP_ROR = 5'd15,
    OP_SWAP = 5'd16, OP_MOV = 5'd17, OP_CPSE = 5'd18
  } op_e;

  localparam logic [FW-1:0] M_ALL   = 6'b111111;
  localparam logic [FW-1:0] M_ZNVS  = 6'b011110;
  localparam logic [FW-1:0] M_CZNVS = 6'b011111;
  localparam logic [FW-1:0] M_NONE  = 6'b000000;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] r_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);
  localparam int unsigned HB = DW / 2;

  logic [DW:0] full;
  logic [HB:0] half;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, x_i} - {1'b0, y_i} - {{DW{1'b0}}, cin_i};
      half = {1'b0, x_i[HB-1:0]} - {1'b0, y_i[HB-1:0]} - {{HB{1'b0}}, cin_i};
    end else begin
      full = {1'b0, x_i} + {1'b0, y_i} + {{DW{1'b0}}, cin_i};
      half = {1'b0, x_i[HB-1:0]} + {1'b0, y_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
    end
    r_o = full[DW-1:0];
    c_o = full[DW];
    h_o = half[HB];
    // signed overflow: sub flips the sign-agreement test on y
    v_o = ((x_i[DW-1] ^ y_i[DW-1]) == sub_i) && (full[DW-1] != x_i[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] r_o,
  output logic          c_o,
  output logic          v_o
);
  localparam int unsigned HB = DW / 2;

  always_comb begin
    r_o = a_i;
    c_o = cin_i;
    unique case (op_i)
      OP_COM:  begin r_o = ~a_i;  c_o = 1'b1; end
      OP_AND:  r_o = a_i & b_i;
      OP_OR:   r_o = a_i | b_i;
      OP_LSL:  begin r_o = {a_i[DW-2:0], 1'b0};  c_o = a_i[DW-1]; end
      OP_LSR:  begin r_o = {1'b0, a_i[DW-1:1]};  c_o = a_i[0]; end
      OP_ROL:  begin r_o = {a_i[DW-2:0], cin_i}; c_o = a_i[DW-1]; end
      OP_ROR:  begin r_o = {cin_i, a_i[DW-1:1]}; c_o = a_i[0]; end
      OP_SWAP: r_o = {a_i[HB-1:0], a_i[DW-1:HB]};
      OP_MOV:  r_o = b_i;
      default: ;
    endcase
    unique case (op_i)
      OP_LSL, OP_LSR, OP_ROL, OP_ROR: v_o = r_o[DW-1] ^ c_o;
      default:                        v_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [FW-1:0] mask_i,
  input  logic [FW-1:0] nxt_i,
  output logic [FW-1:0] q_o
);
  for (genvar k = 0; k < FW; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q_o[k] <= 1'b0;
      else if (we_i && mask_i[k])  q_o[k] <= nxt_i[k];
    end

    // R1: unmasked bits hold
    p_unmasked_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && mask_i[k]) |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          flag_we_i,
  output logic [DW-1:0] result_o,
  output logic          result_we_o,
  output logic          equal_o,
  output logic [FW-1:0] flags_o
);
  op_e           op;
  logic [DW-1:0] ax, ay, ar, lr;
  logic          acin, asub, ac, ah, av, lc, lv;
  logic          use_arith, sticky_z;
  logic [FW-1:0] mask, nxt;
  logic          c_q, z_q;
  logic          n_n, v_n, z_n;

  assign op  = op_e'(op_i);
  assign c_q = flags_o[F_C];
  assign z_q = flags_o[F_Z];

  always_comb begin
    ax = a_i; ay = b_i; acin = 1'b0; asub = 1'b0;
    use_arith = 1'b1; sticky_z = 1'b0;
    mask = M_NONE; result_we_o = 1'b1;
    unique case (op)
      OP_ADD:  mask = M_ALL;
      OP_ADC:  begin acin = c_q; mask = M_ALL; end
      OP_SUB:  begin asub = 1'b1; mask = M_ALL; end
      OP_SBC:  begin asub = 1'b1; acin = c_q; sticky_z = 1'b1; mask = M_ALL; end
      OP_CP:   begin asub = 1'b1; mask = M_ALL; result_we_o = 1'b0; end
      OP_CPC:  begin asub = 1'b1; acin = c_q; sticky_z = 1'b1; mask = M_ALL;
                     result_we_o = 1'b0; end
      OP_NEG:  begin asub = 1'b1; ax = '0; ay = a_i; mask = M_ALL; end
      OP_INC:  begin ay = DW'(1); mask = M_ZNVS; end
      OP_DEC:  begin asub = 1'b1; ay = DW'(1); mask = M_ZNVS; end
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR:
               begin use_arith = 1'b0; mask = M_CZNVS; end
      OP_AND, OP_OR:
               begin use_arith = 1'b0; mask = M_ZNVS; end
      OP_SWAP, OP_MOV:
               use_arith = 1'b0;
      default: begin use_arith = 1'b0; result_we_o = 1'b0; end
    endcase
  end

  alu8_arith u_arith (
    .x_i(ax), .y_i(ay), .cin_i(acin), .sub_i(asub),
    .r_o(ar), .c_o(ac), .h_o(ah), .v_o(av)
  );

  alu8_logic u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .cin_i(c_q),
    .r_o(lr), .c_o(lc), .v_o(lv)
  );

  assign result_o = use_arith ? ar : lr;
  assign equal_o  = (op == OP_CPSE) && (a_i == b_i);

  always_comb begin
    n_n = result_o[DW-1];
    v_n = use_arith ? av : lv;
    z_n = (result_o == '0) && (!sticky_z || z_q);
    nxt = '0;
    nxt[F_C] = use_arith ? ac : lc;
    nxt[F_Z] = z_n;
    nxt[F_N] = n_n;
    nxt[F_V] = v_n;
    nxt[F_S] = n_n ^ v_n;
    nxt[F_H] = ah;
  end

  alu8_flag_reg u_freg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(flag_we_i),
    .mask_i(mask), .nxt_i(nxt), .q_o(flags_o)
  );

  // R13: S stays consistent with N and V
  p_sign_xor_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[F_S] == (flags_o[F_N] ^ flags_o[F_V]));
  // R8: complement forces carry
  p_com_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_COM) |=> flags_o[F_C]);
  // R9: inc/dec keep carry
  p_incdec_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC || op_i == OP_DEC) |=> $stable(flags_o[F_C]));
  // R4: borrow-chained zero never set
  p_sticky_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_SBC || op_i == OP_CPC) && !flags_o[F_Z]) |=> !flags_o[F_Z]);
  // R5/R6: compares never write back
  p_cmp_nowrite_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CP || op_i == OP_CPC || op_i == OP_CPSE) |-> !result_we_o);
  // R6, R12: flag-neutral ops
  p_neutral_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SWAP || op_i == OP_MOV || op_i == OP_CPSE) |=> $stable(flags_o));
  // R6: equality strobe only for compare-and-skip
  p_equal_only_cpse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    equal_o |-> (op_i == OP_CPSE && a_i == b_i));
endmodule

// File: tb/alu8_flags_tb.sv
`timescale 1ns/1ps
module alu8_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       fwe = 1'b0;
  logic [7:0] res;
  logic       rwe, eq;
  logic [5:0] flg;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] r;
    logic       rwe;
    logic       eq;
    logic [5:0] f;
    string      tag;
  } exp_t;
  exp_t q[$];
  logic [5:0] mflags = '0;

  always #2 clk = ~clk;

  alu8_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .flag_we_i(fwe), .result_o(res), .result_we_o(rwe),
    .equal_o(eq), .flags_o(flg)
  );

  function automatic string tag_of(int o);
    case (o)
      0, 1:    return "R3";
      2, 3:    return "R4";
      4, 5:    return "R5";
      6:       return "R7";
      7:       return "R8";
      8, 9:    return "R9";
      10, 11:  return "R10";
      12, 13, 14, 15: return "R11";
      16, 17:  return "R12";
      18:      return "R6";
      default: return "R2";
    endcase
  endfunction

  // reference model from requirements; flags {H,S,V,N,Z,C}
  task automatic model(input int o, input logic [7:0] x, input logic [7:0] y,
                       input logic [5:0] f, output logic [7:0] r,
                       output logic w, output logic e, output logic [5:0] fn);
    int d, hd, ci;
    logic c, h, v, sticky;
    logic [5:0] m;
    c = f[0]; h = f[5]; v = f[3]; sticky = 0; w = 1; e = 0; m = 6'b000000; r = x;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(f[0]) : 0;
        d = int'(x) + int'(y) + ci; hd = int'(x & 8'h0f) + int'(y & 8'h0f) + ci;
        r = d[7:0]; c = d > 255; h = hd > 15;
        v = (x[7] == y[7]) && (r[7] != x[7]); m = 6'b111111;
      end
      2, 3, 4, 5, 6: begin
        logic [7:0] p, s;
        p = (o == 6) ? 8'h00 : x; s = (o == 6) ? x : y;
        ci = (o == 3 || o == 5) ? int'(f[0]) : 0;
        d = int'(p) - int'(s) - ci; hd = int'(p & 8'h0f) - int'(s & 8'h0f) - ci;
        r = d[7:0]; c = d < 0; h = hd < 0;
        v = (p[7] != s[7]) && (r[7] != p[7]); m = 6'b111111;
        sticky = (o == 3 || o == 5); w = !(o == 4 || o == 5);
      end
      7: begin r = ~x; c = 1; v = 0; m = 6'b011111; end
      8: begin r = x + 8'd1; v = (x == 8'h7f); m = 6'b011110; end
      9: begin r = x - 8'd1; v = (x == 8'h80); m = 6'b011110; end
      10: begin r = x & y; v = 0; m = 6'b011110; end
      11: begin r = x | y; v = 0; m = 6'b011110; end
      12: begin r = {x[6:0], 1'b0}; c = x[7]; v = r[7] ^ c; m = 6'b011111; end
      13: begin r = {1'b0, x[7:1]}; c = x[0]; v = r[7] ^ c; m = 6'b011111; end
      14: begin r = {x[6:0], f[0]}; c = x[7]; v = r[7] ^ c; m = 6'b011111; end
      15: begin r = {f[0], x[7:1]}; c = x[0]; v = r[7] ^ c; m = 6'b011111; end
      16: r = {x[3:0], x[7:4]};
      17: r = y;
      18: begin w = 0; e = (x == y); end
      default: w = 0;
    endcase
    begin
      logic [5:0] cand;
      cand[0] = c;
      cand[1] = (r == 8'h00) && (!sticky || f[1]);
      cand[2] = r[7];
      cand[3] = v;
      cand[4] = r[7] ^ v;
      cand[5] = h;
      fn = (cand & m) | (f & ~m);
    end
  endtask

  task automatic apply(input int o, input logic [7:0] x, input logic [7:0] y,
                       input logic we);
    exp_t it;
    logic [5:0] fn;
    @(negedge clk);
    op = o[4:0]; a = x; b = y; fwe = we;
    model(o, x, y, mflags, it.r, it.rwe, it.eq, fn);
    if (we) mflags = fn;
    it.f = mflags;
    it.tag = we ? tag_of(o) : "R1";
    q.push_back(it);
  endtask

  // monitor
  initial begin
    exp_t it;
    logic [7:0] r_s;
    logic w_s, e_s;
    forever begin
      @(posedge clk);
      r_s = res; w_s = rwe; e_s = eq;
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (r_s !== it.r || w_s !== it.rwe || e_s !== it.eq || flg !== it.f) begin
          n_bad++;
          $display("FAIL %s op=%0d a=%h b=%h: got r=%h we=%b eq=%b f=%b exp r=%h we=%b eq=%b f=%b",
                   it.tag, op, a, b, r_s, w_s, e_s, flg, it.r, it.rwe, it.eq, it.f);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #7;
    n_chk++;
    if (flg !== 6'b000000) begin
      n_bad++;
      $display("FAIL R1 reset: got f=%b exp f=000000", flg);
    end
    rst_n = 1'b1;
    // R3 add, carry chain, half carry, overflow
    apply(0, 8'h3a, 8'hc6, 1);
    apply(1, 8'h01, 8'h00, 1);
    apply(0, 8'h7f, 8'h01, 1);
    apply(1, 8'hff, 8'hff, 1);
    // R4 subtract chain and sticky zero
    apply(2, 8'h00, 8'h01, 1);
    apply(3, 8'h01, 8'h00, 1);
    apply(2, 8'h05, 8'h05, 1);
    apply(3, 8'h00, 8'h00, 1);
    apply(2, 8'h80, 8'h01, 1);
    // R5 compares
    apply(4, 8'h10, 8'h20, 1);
    apply(4, 8'h33, 8'h33, 1);
    apply(5, 8'h00, 8'h00, 1);
    apply(5, 8'h01, 8'h01, 1);
    // R6 compare-and-skip
    apply(0, 8'hff, 8'h01, 1);
    apply(18, 8'h42, 8'h42, 1);
    apply(18, 8'h42, 8'h43, 1);
    // R7 negate corners
    apply(6, 8'h01, 8'h00, 1);
    apply(6, 8'hff, 8'h00, 1);
    apply(6, 8'h00, 8'h00, 1);
    apply(6, 8'h80, 8'h00, 1);
    // R8 complement
    apply(7, 8'h0f, 8'h00, 1);
    // R9 inc/dec keep carry
    apply(2, 8'h00, 8'h01, 1);
    apply(8, 8'h7f, 8'h00, 1);
    apply(9, 8'h80, 8'h00, 1);
    apply(9, 8'h01, 8'h00, 1);
    apply(8, 8'hff, 8'h00, 1);
    // R10 logic
    apply(10, 8'hf0, 8'h0f, 1);
    apply(11, 8'h80, 8'h01, 1);
    // R11 shifts and rotates through carry
    apply(12, 8'h81, 8'h00, 1);
    apply(14, 8'h40, 8'h00, 1);
    apply(13, 8'h01, 8'h00, 1);
    apply(15, 8'h02, 8'h00, 1);
    apply(15, 8'h03, 8'h00, 1);
    // R12 swap/move
    apply(16, 8'hfa, 8'h00, 1);
    apply(17, 8'h00, 8'h5c, 1);
    // R2 undefined code, R1 write disabled
    apply(25, 8'h11, 8'h22, 1);
    apply(2, 8'h00, 8'h01, 0);
    apply(7, 8'h00, 8'h00, 0);
    // random sweep
    for (int i = 0; i < 600; i++)
      apply(int'($urandom_range(0, 19)), 8'($urandom), 8'($urandom),
            ($urandom_range(0, 7) != 0));
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule